// File: doc/BRIEF.md
# Side-Road Green Request Logic

This block decides when the signal on a minor side road should be asked to turn from red to green. While the side light is red, it counts vehicles that trip a sensor wire on the side road. It also times how long the red phase has lasted. The timing uses a clock-cycle counter whose limit is 300 seconds times a configurable number of clock ticks per second.

A daylight level picks the car threshold. By day the request needs three or more waiting cars. At night it needs only one. A red phase that has run past its time limit raises the request whatever the count or the time of day. The block also drives its intermediate flags (one-or-more cars, three-or-more cars, red timed out) as outputs.

The sensor and daylight inputs are asynchronous and are synchronised inside the block. The side-red status comes from the same clock domain. The opposite decision, returning the side light from green to red, is made elsewhere.

Top module: `side_green_req`

## Requirements
- R1: While `side_red_i` is high, `car_one_o` is 1 exactly when the number of cars counted in the current red phase is greater than zero. Each red phase starts counting from zero.
- R2: While `side_red_i` is high, `car_three_o` is 1 exactly when the car count is greater than two.
- R3: One car is counted per rising edge of `trip_i`, however long it stays high. A rising edge that is held for at least two clock cycles shows in the flags no later than three rising clock edges after it is first sampled.
- R4: The car count saturates at 2**CAR_CNT_W-1 and does not wrap. With the default width of 3, ten cars leave both car flags set.
- R5: `red_timeout_o` stays 0 for the first TICKS_PER_SEC*300-1 rising clock edges of a red phase. It becomes 1 after edge TICKS_PER_SEC*300 and holds while red lasts.
- R6: With `daylight_i` = 1 and no timeout, `green_req_o` equals `car_three_o`.
- R7: With `daylight_i` = 0 and no timeout, `green_req_o` equals `car_one_o`.
- R8: `green_req_o` is 1 whenever `red_timeout_o` is 1, regardless of daylight or car count.
- R9: When `side_red_i` is low, all four outputs are 0 in the same cycle. The car count and the red timer are cleared, so trips seen during green are not counted in the next red phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trip_i | input | 1 | Trip-wire sensor level, asynchronous |
| daylight_i | input | 1 | 1 = daylight, 0 = night, asynchronous |
| side_red_i | input | 1 | 1 while the side-road light is red |
| green_req_o | output | 1 | Request to switch the side light to green |
| car_one_o | output | 1 | At least one car waiting |
| car_three_o | output | 1 | At least three cars waiting |
| red_timeout_o | output | 1 | Red phase has lasted past the time limit |

## Verification
The car-threshold path and the red timeout can become true on the same clock edge. The bench provokes this in daylight. It counts two cars early in a red phase, then raises the third trip pulse so that its count increment lands on exactly the edge where the timeout also fires. One cycle before that edge, the request, the three-car flag and the timeout must all still be 0. On that edge all three must be 1 together, with no cycle in which only one of the two causes is visible.

// File: rtl/sgr_pkg.sv
package sgr_pkg;

  // Number of clock cycles in the red-phase time limit.
  function automatic int unsigned red_limit_ticks(input int unsigned ticks_per_sec,
                                                  input int unsigned limit_sec);
    return ticks_per_sec * limit_sec;
  endfunction

  // Request decision: the timeout wins; otherwise daylight picks the car threshold.
  function automatic logic green_decision(input logic timeout,
                                          input logic day,
                                          input logic one_car,
                                          input logic three_cars);
    return timeout | (day ? three_cars : one_car);
  endfunction

endpackage

// File: rtl/sgr_sync.sv
module sgr_sync #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage1, stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d_i;
      stage2 <= stage1;
    end
  end

  assign q_o = stage2;
endmodule

// File: rtl/sgr_car_counter.sv
module sgr_car_counter #(
  parameter int unsigned CNT_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic red_i,
  input  logic trip_s_i,
  output logic one_o,
  output logic three_o
);
  logic             trip_d;
  logic             trip_rise;
  logic             at_max;
  logic [CNT_W-1:0] cnt;

  assign trip_rise = trip_s_i & ~trip_d;
  assign at_max    = (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trip_d <= 1'b0;
      cnt    <= '0;
    end else begin
      trip_d <= trip_s_i;
      if (!red_i)                  cnt <= '0;
      else if (trip_rise && !at_max) cnt <= cnt + 1'b1;
    end
  end

  assign one_o   = red_i && (cnt != '0);
  assign three_o = red_i && (cnt > CNT_W'(2));

  // R1: the count never drops while red continues
  a_r1_count_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    (red_i && $past(red_i)) |-> (cnt >= $past(cnt)));

  // R4: a saturated count stays saturated
  a_r4_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (at_max && red_i) |=> (at_max || !red_i));

  // R3: at most one step per cycle and only on a rising edge
  a_r3_step_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (red_i && !trip_rise) |=> (cnt == $past(cnt) || !red_i));

  // R9: leaving red clears the count
  a_r9_count_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !red_i |=> (cnt == '0));
endmodule

// File: rtl/sgr_red_timer.sv
module sgr_red_timer #(
  parameter int unsigned LIMIT = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic red_i,
  output logic timeout_o
);
  localparam int unsigned TW = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] LIMIT_V = TW'(LIMIT);

  logic [TW-1:0] cnt;
  logic          expired;

  assign expired = (cnt == LIMIT_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (!red_i)   cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end

  assign timeout_o = red_i && expired;

  // R5: once expired, the timeout holds for the rest of the red phase
  a_r5_timeout_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_o && red_i) |=> (timeout_o || !red_i));

  // R5: the timeout cannot rise unless red was already present one cycle earlier
  a_r5_needs_red_history: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> $past(red_i));

  // R9: leaving red clears the timer
  a_r9_timer_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !red_i |=> (cnt == '0));
endmodule

// File: rtl/side_green_req.sv
module side_green_req #(
  parameter int unsigned TICKS_PER_SEC = 1_000_000,
  parameter int unsigned RED_LIMIT_SEC = 300,
  parameter int unsigned CAR_CNT_W     = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_i,
  input  logic daylight_i,
  input  logic side_red_i,
  output logic green_req_o,
  output logic car_one_o,
  output logic car_three_o,
  output logic red_timeout_o
);
  import sgr_pkg::*;

  localparam int unsigned LIMIT_TICKS = red_limit_ticks(TICKS_PER_SEC, RED_LIMIT_SEC);

  logic [1:0] async_in, synced;
  logic       trip_s, day_s;

  assign async_in = {trip_i, daylight_i};
  assign {trip_s, day_s} = synced;

  sgr_sync #(.WIDTH(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (async_in),
    .q_o   (synced)
  );

  sgr_car_counter #(.CNT_W(CAR_CNT_W)) u_cars (
    .clk      (clk),
    .rst_n    (rst_n),
    .red_i    (side_red_i),
    .trip_s_i (trip_s),
    .one_o    (car_one_o),
    .three_o  (car_three_o)
  );

  sgr_red_timer #(.LIMIT(LIMIT_TICKS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .red_i     (side_red_i),
    .timeout_o (red_timeout_o)
  );

  assign green_req_o = side_red_i &&
                       green_decision(red_timeout_o, day_s, car_one_o, car_three_o);

  // R8: a timeout always produces a request
  a_r8_timeout_requests: assert property (@(posedge clk) disable iff (!rst_n)
    red_timeout_o |-> green_req_o);

  // R9: no output is active outside red
  a_r9_quiet_in_green: assert property (@(posedge clk) disable iff (!rst_n)
    !side_red_i |-> !(green_req_o || car_one_o || car_three_o || red_timeout_o));

  // R2: three cars imply one car
  a_r2_flags_nested: assert property (@(posedge clk) disable iff (!rst_n)
    car_three_o |-> car_one_o);

  // R7: a night request needs a car or a timeout
  a_r7_night_needs_car: assert property (@(posedge clk) disable iff (!rst_n)
    (green_req_o && !day_s) |-> (car_one_o || red_timeout_o));
endmodule

// File: tb/side_green_req_bench.sv
`timescale 1ns/1ps
module side_green_req_bench;
  localparam int unsigned TPS   = 2;
  localparam int unsigned LIMIT = TPS * 300;

  logic clk = 1'b0;
  logic rst_n, trip, day, red;
  logic req, one, three, tmo;
  int   checks = 0;
  int   errors = 0;

  always #2 clk = ~clk;

  side_green_req #(.TICKS_PER_SEC(TPS), .RED_LIMIT_SEC(300), .CAR_CNT_W(3)) u_side_green_req (
    .clk           (clk),
    .rst_n         (rst_n),
    .trip_i        (trip),
    .daylight_i    (day),
    .side_red_i    (red),
    .green_req_o   (req),
    .car_one_o     (one),
    .car_three_o   (three),
    .red_timeout_o (tmo)
  );

  task automatic chk(input string rq, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", rq, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic car();
    trip = 1'b1; cycles(2);
    trip = 1'b0; cycles(2);
  endtask

  task automatic go_green();
    red = 1'b0; cycles(3);
  endtask

  task automatic set_day(input logic d);
    day = d; cycles(3);
  endtask

  task automatic t_reset();
    chk("R9", "reset req", req, 1'b0);
    chk("R9", "reset one", one, 1'b0);
    chk("R9", "reset tmo", tmo, 1'b0);
  endtask

  task automatic t_night_one();
    set_day(1'b0);
    red = 1'b1; cycles(2);
    chk("R1", "night no car one", one, 1'b0);
    chk("R7", "night no car req", req, 1'b0);
    car();
    chk("R1", "night one car flag", one, 1'b1);
    chk("R7", "night one car req", req, 1'b1);
    chk("R2", "night one car three", three, 1'b0);
    go_green();
  endtask

  task automatic t_day_three();
    set_day(1'b1);
    red = 1'b1; cycles(2);
    car(); car();
    chk("R6", "day two cars req", req, 1'b0);
    chk("R2", "day two cars three", three, 1'b0);
    chk("R1", "day two cars one", one, 1'b1);
    car();
    chk("R2", "day three cars flag", three, 1'b1);
    chk("R6", "day three cars req", req, 1'b1);
    set_day(1'b0);
    chk("R7", "night after three req", req, 1'b1);
    go_green();
  endtask

  task automatic t_held_trip();
    set_day(1'b1);
    red = 1'b1; cycles(2);
    trip = 1'b1;
    cycles(1);
    chk("R3", "latency not before third edge", one, 1'b0);
    cycles(2);
    chk("R3", "latency by third edge", one, 1'b1);
    cycles(20);
    trip = 1'b0; cycles(4);
    chk("R3", "held trip counts once", three, 1'b0);
    chk("R3", "held trip one flag", one, 1'b1);
    go_green();
  endtask

  task automatic t_saturate();
    set_day(1'b1);
    red = 1'b1; cycles(2);
    for (int i = 0; i < 10; i++) car();
    chk("R4", "ten cars three flag", three, 1'b1);
    chk("R4", "ten cars one flag", one, 1'b1);
    chk("R6", "ten cars day req", req, 1'b1);
    go_green();
  endtask

  task automatic t_green_ignored();
    set_day(1'b0);
    red = 1'b1; cycles(2);
    car();
    red = 1'b0; #1;
    chk("R9", "red drop req", req, 1'b0);
    chk("R9", "red drop one", one, 1'b0);
    cycles(2);
    car(); car(); car();
    chk("R9", "green cars req", req, 1'b0);
    red = 1'b1; cycles(2);
    chk("R9", "green cars not carried one", one, 1'b0);
    chk("R1", "new phase count zero req", req, 1'b0);
    go_green();
  endtask

  task automatic t_timeout();
    set_day(1'b1);
    red = 1'b1;
    cycles(LIMIT - 1);
    chk("R5", "timeout not early", tmo, 1'b0);
    chk("R8", "no req before timeout", req, 1'b0);
    cycles(1);
    chk("R5", "timeout at limit", tmo, 1'b1);
    chk("R8", "timeout forces req day", req, 1'b1);
    set_day(1'b0);
    chk("R8", "timeout forces req night", req, 1'b1);
    chk("R5", "timeout holds", tmo, 1'b1);
    red = 1'b0; #1;
    chk("R9", "timeout cleared by green", tmo, 1'b0);
    cycles(3);
    red = 1'b1; cycles(5);
    chk("R9", "timer restarts", tmo, 1'b0);
    go_green();
  endtask

  task automatic t_collide();
    set_day(1'b1);
    red = 1'b1;
    car(); car();
    cycles(LIMIT - 3 - 8);
    trip = 1'b1;
    cycles(1);
    chk("R6", "collide prior req", req, 1'b0);
    cycles(1);
    trip = 1'b0;
    chk("R6", "collide edge-1 req", req, 1'b0);
    chk("R2", "collide edge-1 three", three, 1'b0);
    chk("R5", "collide edge-1 tmo", tmo, 1'b0);
    cycles(1);
    chk("R2", "collide three", three, 1'b1);
    chk("R5", "collide tmo", tmo, 1'b1);
    chk("R8", "collide req", req, 1'b1);
    go_green();
  endtask

  initial begin
    rst_n = 1'b0; trip = 1'b0; day = 1'b0; red = 1'b0;
    cycles(3);
    t_reset();
    rst_n = 1'b1;
    cycles(2);
    t_night_one();
    t_day_three();
    t_held_trip();
    t_saturate();
    t_green_ignored();
    t_timeout();
    t_collide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule